// File: doc/BRIEF.md
# Upset-Tolerant Sequencing State Machine

This block is a small control sequencer whose state register is stored as a redundant codeword rather than a bare index. The sequence has eight states: an idle state and seven working states. A start request leaves idle, each step request advances one working state, and a step in the last working state returns to idle and raises a completion pulse. An abort request returns to idle from any working state.

A build-time parameter selects the state encoding: plain binary, one-hot, binary with a parity bit (minimum distance 2), or a six-bit minimum-distance-3 code. Every cycle the stored word is decoded against the codebook. With the distance-3 code, a word one bit away from a legal codeword is taken as that codeword, so the sequence carries on unchanged and a corrected flag is raised. With one-hot or parity encoding, an illegal word is detected and the machine falls back to idle. With binary encoding, upsets are neither seen nor handled. An injection input XORs a mask into the word written at a clock edge, so tests can model an upset in the state register. The next state is worked out on the decoded index and then encoded again. Because of this, the register always holds the full codeword, and optimisation cannot fold the redundant bits away.

Top module: `seu_hfsm_ctrl`

## Requirements
- R1: A synchronous reset loads the idle codeword. In the cycle after a reset edge, state_idx is 0 and done, upset_fixed and upset_seen are all 0, whatever upset_mask holds.
- R2: In idle (index 0), start moves to index 1 and step alone has no effect. Outside idle, start has no effect.
- R3: In indices 1 to 6, step without abort advances the index by exactly one at the next edge. With neither step nor abort, the index holds.
- R4: Step in index 7 without abort returns to index 0. It also drives done high for exactly the one cycle after that edge.
- R5: Abort in indices 1 to 7 returns to index 0 at the next edge, with no done pulse. Abort takes priority over step.
- R6: The encodings are selected as follows. ENC=0 is a 3-bit binary index. ENC=1 is 8 bits with bit i set for state i. ENC=2 is 4 bits: the index in bits 2:0 and even parity of the index in bit 3. ENC=3 is 6 bits: the index in bits 2:0, bit3=i0^i1, bit4=i1^i2 and bit5=i0^i2, which gives minimum distance 3.
- R7: upset_mask has the width of the code and carries at most one set bit. It is XORed into the word stored at that edge (reset excepted).
- R8: With ENC=3, a single flipped bit leaves the state_idx and done sequence identical to an upset-free run. upset_fixed is high exactly in the cycle the corrupted word is held, and upset_seen stays 0.
- R9: With ENC=1 or ENC=2, a single flipped bit makes upset_seen high and state_idx 0 for the cycle the illegal word is held. At the next edge the machine goes to idle and ignores start, step and abort in that cycle. No done pulse results.
- R10: With ENC=0, a flip of bit k moves the machine silently to the index XOR (1<<k). Both flags stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Leave idle for the first working state |
| step | input | 1 | Advance one working state |
| abort | input | 1 | Return to idle from a working state |
| upset_mask | input | CW | Bits XORed into the stored state word at the edge (one-hot or zero) |
| state_idx | output | 3 | Decoded current state index, 0 while the word is illegal |
| done | output | 1 | One-cycle pulse after the sequence completes |
| upset_fixed | output | 1 | Stored word was one bit off a codeword and has been corrected |
| upset_seen | output | 1 | Stored word is illegal and not correctable |

## Verification
The bench runs four copies, one per encoding, on the same request stream and compares each against a single index-level model. Directed walks check that all four encodings agree when no upset occurs, covering start in idle, holding, the final step with its done pulse, and abort racing step. The distance-3 copy then takes an upset on every edge, with the flipped bit rotated across all six positions and all eight states, and its output must still match the model exactly. This separates true correction from simple detection. Single injections into the parity and one-hot copies show the fall to idle. An injection into the binary copy shows the silent jump. A long seeded random run mixes requests with random single-bit upsets into the distance-3 copy.

// File: rtl/seu_fsm_pkg.sv
`timescale 1ns/1ps
package seu_fsm_pkg;
   localparam int ENC_BIN    = 0;
   localparam int ENC_ONEHOT = 1;
   localparam int ENC_PAR    = 2;
   localparam int ENC_HAM3   = 3;

   localparam int IDX_W  = 3;
   localparam int NUM_ST = 1 << IDX_W;
   localparam int MAX_CW = NUM_ST;

   typedef logic [IDX_W-1:0] idx_t;

   function automatic int code_width(input int enc);
      case (enc)
         ENC_BIN:    return IDX_W;
         ENC_ONEHOT: return NUM_ST;
         ENC_PAR:    return IDX_W + 1;
         default:    return IDX_W + 3;
      endcase
   endfunction

   function automatic logic [MAX_CW-1:0] code_of(input int enc, input idx_t s);
      logic [MAX_CW-1:0] w;
      w = '0;
      case (enc)
         ENC_BIN:    w[IDX_W-1:0] = s;
         ENC_ONEHOT: w[s] = 1'b1;
         ENC_PAR:    w[IDX_W:0] = {^s, s};
         default:    w[IDX_W+2:0] = {s[0] ^ s[2], s[1] ^ s[2], s[0] ^ s[1], s};
      endcase
      return w;
   endfunction
endpackage

// File: rtl/seu_code_enc.sv
`timescale 1ns/1ps
module seu_code_enc
   import seu_fsm_pkg::*;
#(
   parameter int  ENC = ENC_HAM3,
   localparam int CW  = code_width(ENC)
) (
   input  idx_t          idx,
   output logic [CW-1:0] code
);
   always_comb begin
      code = CW'(code_of(ENC, idx));
   end
endmodule

// File: rtl/seu_code_dec.sv
`timescale 1ns/1ps
module seu_code_dec
   import seu_fsm_pkg::*;
#(
   parameter int  ENC = ENC_HAM3,
   localparam int CW  = code_width(ENC)
) (
   input  logic [CW-1:0] code,
   output idx_t          idx,
   output logic          legal,
   output logic          fixed
);
   generate
      if (ENC == ENC_BIN) begin : g_plain
         always_comb begin
            idx   = code[IDX_W-1:0];
            legal = 1'b1;
            fixed = 1'b0;
         end
      end else begin : g_search
         localparam bit CAN_FIX = (ENC == ENC_HAM3);
         logic [CW-1:0] cand_w [NUM_ST];
         idx_t          hit_idx;
         idx_t          near_idx;
         logic          hit;
         logic [3:0]    near_cnt;

         for (genvar g = 0; g < NUM_ST; g++) begin : g_cw
            assign cand_w[g] = CW'(code_of(ENC, IDX_W'(g)));
         end

         always_comb begin
            hit      = 1'b0;
            hit_idx  = '0;
            near_idx = '0;
            near_cnt = '0;
            for (int i = 0; i < NUM_ST; i++) begin
               if (code == cand_w[i]) begin
                  hit     = 1'b1;
                  hit_idx = IDX_W'(i);
               end else if ($countones(code ^ cand_w[i]) == 1) begin
                  near_cnt = near_cnt + 4'd1;
                  near_idx = IDX_W'(i);
               end
            end
            fixed = CAN_FIX && !hit && (near_cnt == 4'd1);
            legal = hit || fixed;
            idx   = hit ? hit_idx : (fixed ? near_idx : '0);
         end
      end
   endgenerate
endmodule

// File: rtl/seu_seq_next.sv
`timescale 1ns/1ps
module seu_seq_next
   import seu_fsm_pkg::*;
(
   input  idx_t cur,
   input  logic legal,
   input  logic start,
   input  logic step,
   input  logic abort,
   output idx_t nxt,
   output logic fin
);
   localparam idx_t IDLE = '0;
   localparam idx_t LAST = IDX_W'(NUM_ST - 1);

   always_comb begin
      nxt = cur;
      fin = 1'b0;
      if (!legal) begin
         nxt = IDLE;
      end else if (cur == IDLE) begin
         if (start) nxt = IDX_W'(1);
      end else if (abort) begin
         nxt = IDLE;
      end else if (step) begin
         if (cur == LAST) begin
            nxt = IDLE;
            fin = 1'b1;
         end else begin
            nxt = cur + IDX_W'(1);
         end
      end
   end
endmodule

// File: rtl/seu_hfsm_ctrl.sv
`timescale 1ns/1ps
module seu_hfsm_ctrl
   import seu_fsm_pkg::*;
#(
   parameter int  ENC = ENC_HAM3,
   localparam int CW  = code_width(ENC)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic          step,
   input  logic          abort,
   input  logic [CW-1:0] upset_mask,
   output logic [2:0]    state_idx,
   output logic          done,
   output logic          upset_fixed,
   output logic          upset_seen
);
   localparam logic [CW-1:0] IDLE_CODE = CW'(code_of(ENC, '0));

   initial begin : elab_chk
      a_r6_enc_range: assert (ENC >= ENC_BIN && ENC <= ENC_HAM3)
         else $error("ENC must be 0..3");
      a_r6_idx_width: assert (IDX_W == 3)
         else $error("index width must be 3");
   end

   logic [CW-1:0] st_q;
   logic [CW-1:0] st_d;
   idx_t          cur_idx;
   idx_t          nxt_idx;
   logic          cur_ok;
   logic          cur_fix;
   logic          fin;
   logic          done_q;

   seu_code_dec #(.ENC(ENC)) u_dec (
      .code  (st_q),
      .idx   (cur_idx),
      .legal (cur_ok),
      .fixed (cur_fix)
   );

   seu_seq_next u_next (
      .cur   (cur_idx),
      .legal (cur_ok),
      .start (start),
      .step  (step),
      .abort (abort),
      .nxt   (nxt_idx),
      .fin   (fin)
   );

   seu_code_enc #(.ENC(ENC)) u_enc (
      .idx  (nxt_idx),
      .code (st_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= IDLE_CODE;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d ^ upset_mask;
         done_q <= fin;
      end
   end

   assign state_idx   = cur_idx;
   assign done        = done_q;
   assign upset_fixed = cur_fix;
   assign upset_seen  = !cur_ok;

   a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (state_idx == 3'd0 && !done && !upset_seen && !upset_fixed));

   a_r7_mask_single: assert property (@(posedge clk) disable iff (rst)
      $onehot0(upset_mask));

   a_r3_step_adv: assert property (@(posedge clk) disable iff (rst)
      (state_idx != 3'd0 && state_idx != 3'd7 && step && !abort && !upset_seen
       && upset_mask == '0) |=> (state_idx == $past(state_idx) + 3'd1));

   a_r4_last_step: assert property (@(posedge clk) disable iff (rst)
      (state_idx == 3'd7 && step && !abort && !upset_seen && upset_mask == '0)
      |=> (done && state_idx == 3'd0));

   a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   a_r5_abort_idle: assert property (@(posedge clk) disable iff (rst)
      (state_idx != 3'd0 && abort && !upset_seen && upset_mask == '0)
      |=> (state_idx == 3'd0 && !done));

   a_r8_fix_one_cycle: assert property (@(posedge clk) disable iff (rst)
      (upset_fixed && upset_mask == '0) |=> !upset_fixed);

   generate
      if (ENC == ENC_HAM3) begin : g_chk_fix
         a_r8_never_lost: assert property (@(posedge clk) disable iff (rst)
            !upset_seen);
      end else if (ENC != ENC_BIN) begin : g_chk_detect
         a_r9_safe_idle: assert property (@(posedge clk) disable iff (rst)
            (upset_seen && upset_mask == '0)
            |=> (state_idx == 3'd0 && !upset_seen && !done));
      end
   endgenerate
endmodule

// File: tb/seu_hfsm_ctrl_bench.sv
`timescale 1ns/1ps
module seu_hfsm_ctrl_bench;
   logic clk;
   logic rst;
   logic start, step, abort;
   logic [2:0] m0;
   logic [7:0] m1;
   logic [3:0] m2;
   logic [5:0] m3;

   logic [2:0] o_idx  [4];
   logic       o_done [4];
   logic       o_fix  [4];
   logic       o_seen [4];

   int  n_tests = 0;
   int  n_fail  = 0;
   int  m_st    = 0;
   bit  m_done  = 0;
   bit  clean [4];
   bit  inj3;
   bit  finished = 0;

   initial clk = 1'b0;
   always #5 clk = ~clk;

   seu_hfsm_ctrl #(.ENC(0)) u_bin (
      .clk(clk), .rst(rst), .start(start), .step(step), .abort(abort),
      .upset_mask(m0), .state_idx(o_idx[0]), .done(o_done[0]),
      .upset_fixed(o_fix[0]), .upset_seen(o_seen[0]));
   seu_hfsm_ctrl #(.ENC(1)) u_oh (
      .clk(clk), .rst(rst), .start(start), .step(step), .abort(abort),
      .upset_mask(m1), .state_idx(o_idx[1]), .done(o_done[1]),
      .upset_fixed(o_fix[1]), .upset_seen(o_seen[1]));
   seu_hfsm_ctrl #(.ENC(2)) u_par (
      .clk(clk), .rst(rst), .start(start), .step(step), .abort(abort),
      .upset_mask(m2), .state_idx(o_idx[2]), .done(o_done[2]),
      .upset_fixed(o_fix[2]), .upset_seen(o_seen[2]));
   seu_hfsm_ctrl #(.ENC(3)) u_seu_hfsm_ctrl (
      .clk(clk), .rst(rst), .start(start), .step(step), .abort(abort),
      .upset_mask(m3), .state_idx(o_idx[3]), .done(o_done[3]),
      .upset_fixed(o_fix[3]), .upset_seen(o_seen[3]));

   task automatic chk(input string tag, input int got, input int exp);
      n_tests++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   // one clock: drive, model, check every copy still expected to follow the model
   task automatic tick(input bit s, input bit p, input bit a,
                       input int tgt, input int b, input string tag);
      start = s; step = p; abort = a;
      m0 = '0; m1 = '0; m2 = '0; m3 = '0;
      if (tgt == 0) m0[b] = 1'b1;
      if (tgt == 1) m1[b] = 1'b1;
      if (tgt == 2) m2[b] = 1'b1;
      if (tgt == 3) m3[b] = 1'b1;
      inj3 = (tgt == 3) && !rst;
      @(posedge clk);
      #1;
      if (rst) begin
         m_st = 0; m_done = 0;
      end else begin
         m_done = 0;
         if (m_st == 0) begin
            if (s) m_st = 1;
         end else if (a) begin
            m_st = 0;
         end else if (p) begin
            if (m_st == 7) begin m_st = 0; m_done = 1; end
            else m_st = m_st + 1;
         end
      end
      for (int i = 0; i < 4; i++) begin
         if (clean[i]) begin
            chk(tag, int'(o_idx[i]), m_st);
            chk(tag, int'(o_done[i]), int'(m_done));
            chk(tag, int'(o_seen[i]), 0);
            chk((i == 3) ? "R8" : tag, int'(o_fix[i]), (i == 3) ? int'(inj3) : 0);
         end
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      for (int i = 0; i < 4; i++) clean[i] = 1'b1;
      tick(0, 0, 0, -1, 0, "R1");
      tick(1, 1, 1, -1, 0, "R1");
      rst = 1'b0;
   endtask

   initial begin
      rst = 1'b1; start = 0; step = 0; abort = 0;
      m0 = '0; m1 = '0; m2 = '0; m3 = '0;
      void'($urandom(32'h5EED_0001));
      do_reset();

      // R2: step alone in idle does nothing, start leaves idle, start later ignored
      tick(0, 1, 0, -1, 0, "R2");
      tick(0, 0, 1, -1, 0, "R2");
      tick(1, 0, 0, -1, 0, "R2");
      tick(1, 0, 0, -1, 0, "R2");
      // R3: advance and hold
      for (int k = 0; k < 6; k++) begin
         tick(0, 1, 0, -1, 0, "R3");
         tick(0, 0, 0, -1, 0, "R3");
      end
      // R4: last step gives done, then done drops
      tick(0, 1, 0, -1, 0, "R4");
      chk("R4", int'(o_done[3]), 1);
      tick(0, 0, 0, -1, 0, "R4");
      chk("R4", int'(o_done[3]), 0);
      // R5: abort beats step
      tick(1, 0, 0, -1, 0, "R5");
      tick(0, 1, 0, -1, 0, "R5");
      tick(0, 1, 1, -1, 0, "R5");
      chk("R5", int'(o_idx[3]), 0);
      for (int k = 0; k < 7; k++) tick(k == 0, k != 0, 0, -1, 0, "R5");
      tick(0, 1, 1, -1, 0, "R5");
      chk("R5", int'(o_done[3]), 0);

      // R8: distance-3 copy takes an upset on every edge, all bits and states
      for (int pass = 0; pass < 6; pass++) begin
         do_reset();
         for (int k = 0; k < 12; k++) tick(1, 1, 0, 3, (pass + k) % 6, "R8");
         tick(0, 0, 0, -1, 0, "R8");
         chk("R8", int'(o_fix[3]), 0);
      end

      // R9: parity copy, flip parity bit while stepping 2 -> 3
      do_reset();
      tick(1, 0, 0, -1, 0, "R2");
      tick(0, 1, 0, -1, 0, "R3");
      clean[2] = 1'b0;
      tick(0, 1, 0, 2, 3, "R9");
      chk("R9", int'(o_seen[2]), 1);
      chk("R9", int'(o_idx[2]), 0);
      tick(1, 1, 0, -1, 0, "R9");
      chk("R9", int'(o_seen[2]), 0);
      chk("R9", int'(o_idx[2]), 0);
      chk("R9", int'(o_done[2]), 0);
      tick(1, 0, 0, -1, 0, "R9");
      chk("R9", int'(o_idx[2]), 1);

      // R9: one-hot copy, clear the hot bit, then set an extra bit
      do_reset();
      tick(1, 0, 0, -1, 0, "R2");
      clean[1] = 1'b0;
      tick(0, 1, 0, 1, 2, "R9");
      chk("R9", int'(o_seen[1]), 1);
      chk("R9", int'(o_idx[1]), 0);
      tick(0, 0, 0, -1, 0, "R9");
      chk("R9", int'(o_seen[1]), 0);
      chk("R9", int'(o_idx[1]), 0);
      do_reset();
      tick(1, 0, 0, -1, 0, "R2");
      clean[1] = 1'b0;
      tick(0, 0, 0, 1, 5, "R9");
      chk("R9", int'(o_seen[1]), 1);
      chk("R9", int'(o_fix[1]), 0);

      // R10: binary copy jumps silently 3 -> 3^4 = 7, then completes early
      do_reset();
      tick(1, 0, 0, -1, 0, "R2");
      tick(0, 1, 0, -1, 0, "R3");
      clean[0] = 1'b0;
      tick(0, 1, 0, 0, 2, "R10");
      chk("R10", int'(o_idx[0]), 7);
      chk("R10", int'(o_seen[0]), 0);
      chk("R10", int'(o_fix[0]), 0);
      tick(0, 1, 0, -1, 0, "R10");
      chk("R10", int'(o_done[0]), 1);

      // random mix, upsets only into the distance-3 copy (R3, R8)
      do_reset();
      for (int n = 0; n < 4000; n++) begin
         bit s, p, a;
         int t;
         s = ($urandom_range(0, 3) == 0);
         p = ($urandom_range(0, 1) == 1);
         a = ($urandom_range(0, 11) == 0);
         t = ($urandom_range(0, 3) == 0) ? 3 : -1;
         tick(s, p, a, t, int'($urandom_range(0, 5)), "R3");
      end
      tick(0, 0, 0, -1, 0, "R8");

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule